// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns characters written in parallel by a host into an asynchronous start-stop serial stream. A write lands in a holding register. When the output shifter has nothing in progress, the character moves into it and the frame begins. The host can therefore queue the next character while the current one is still on the line. Two status outputs tell the host whether the holding register can take a write and whether the line has gone quiet.

The frame shape comes from mode inputs: 5 to 8 data bits, optional parity (odd or even), and one, one-and-a-half or two stop bits. Bit timing comes from a transmit tick enable, `tx_tick`, which pulses at 1, 16 or 64 times the bit rate. The mode inputs are captured when a character moves into the shifter, so later changes only affect later frames.

The controller has five states. TX_IDLE holds the line high. TX_START drives the low start bit. TX_DATA shifts out the data bits. TX_PARITY sends the parity bit. TX_STOP holds the line high for the whole stop interval. The transitions are:
- load: TX_IDLE to TX_START when the holding register is full.
- start_done: TX_START to TX_DATA.
- data_next: TX_DATA to itself while data bits remain.
- data_last: TX_DATA to TX_PARITY, or to TX_STOP when parity is off.
- parity_done: TX_PARITY to TX_STOP.
- chain: TX_STOP to TX_START when another character is waiting.
- stop_done: TX_STOP to TX_IDLE when nothing is waiting.

Top module: `serial_tx_dbuf`

## Requirements
- R1: A written character waits in the holding register and moves to the shifter only when no frame is in progress, or at the clock edge that ends the last stop interval; the next frame then starts with no idle gap.
- R2: `hold_empty` is high exactly when the holding register is empty. It falls the cycle after an accepted write and rises the cycle after the character moves to the shifter.
- R3: `shift_empty` is high exactly when no frame is in progress. It falls in the cycle after the transfer and rises after the last stop tick.
- R4: A frame is a low start bit, then the data bits least significant first, with `cfg_len` 00/01/10/11 giving 5/6/7/8 bits. Unused upper data bits are never sent.
- R5: With `cfg_par_en`=1, a parity bit follows the data. It makes the count of ones in the data bits plus the parity bit odd when `cfg_par_odd`=1, and even when it is 0.
- R6: `cfg_rate` 00 gives 1 tick per bit, 01 gives 16 ticks and 10 or 11 gives 64 ticks. Each bit changes at the clock edge where its last tick is sampled.
- R7: `cfg_stop` 00 gives one stop bit, 01 one and a half, and 10 or 11 two. Half a bit is 8 ticks at 16x and 32 ticks at 64x. At 1x, the 01 code gives two stop bits.
- R8: A write while the holding register is full is ignored. `hold_empty` stays low, and the dropped character is never sent.
- R9: After reset, `ser_out`, `hold_empty` and `shift_empty` are all high and no frame is in progress.
- R10: The mode inputs are sampled at the transfer into the shifter. Changing them mid-frame does not change the frame in progress.
- R11: While no frame is in progress, `ser_out` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_tick | input | 1 | Transmit clock enable at 1/16/64 times the bit rate |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Character to transmit |
| cfg_len | input | 2 | Data length code: 00=5 bits, 01=6, 10=7, 11=8 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop | input | 2 | Stop length code: 00=1, 01=1.5, 1x=2 |
| cfg_rate | input | 2 | Ticks per bit: 00=1, 01=16, 1x=64 |
| ser_out | output | 1 | Serial line, high when idle |
| hold_empty | output | 1 | Holding register can take a write |
| shift_empty | output | 1 | No frame in progress |

## Verification
A write sampled at edge E makes `hold_empty` low after E. The transfer happens at E+1, so after E+1 the start bit is on the line, `shift_empty` is low and `hold_empty` is high again. Every later line change falls on the edge that samples the last tick of the current bit. A behavioural model in the bench updates its queued bit list at each rising edge, and the bench compares all three outputs at the following falling edge, one settled half-cycle after every register update. Directed measurements count the falling edges spent low in a start bit, or spent busy in a whole frame, against tick totals worked out from the requirements.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic [1:0] stop;
        logic [1:0] rate;
    } frame_cfg_t;

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic          full,
    output logic [DW-1:0] data
);
    logic          full_q;
    logic [DW-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (wr_en && !full_q) begin
            full_q <= 1'b1;
            data_q <= wr_data;
        end
    end

    assign full = full_q;
    assign data = data_q;

    // R8
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        full_q |=> $stable(data_q));

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             bit_done
);
    logic [CNT_W-1:0] cnt_q;

    assign bit_done = run && tick && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= bit_done ? '0 : cnt_q + 1'b1;
        end
    end

    // R6
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q < limit));

endmodule

// File: rtl/sertx_frame_fsm.sv
module sertx_frame_fsm
    import sertx_pkg::*;
#(
    parameter int DW       = 8,
    parameter int CNT_W    = 8,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_full,
    input  logic [DW-1:0]    hold_data,
    input  frame_cfg_t       cfg,
    input  logic             bit_done,
    output logic             take,
    output logic             run,
    output logic [CNT_W-1:0] limit,
    output logic             ser_out,
    output logic             shift_empty
);
    localparam int MIN_BITS = 5;
    localparam int LEN_SPAN = DW - MIN_BITS;
    localparam int IDX_W    = $clog2(DW);

    tx_state_e        state_q, state_d;
    logic [DW-1:0]    shreg_q, shreg_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             par_q, par_d;
    logic [1:0]       len_q, len_d;
    logic             paren_q, paren_d;
    logic [1:0]       stop_q, stop_d;
    logic [1:0]       rate_q, rate_d;
    logic             load;
    logic [DW-1:0]    masked;
    logic [IDX_W-1:0] last_idx;

    function automatic logic [CNT_W-1:0] ticks_per_bit(input logic [1:0] r);
        unique case (r)
            2'b00:   return CNT_W'(1);
            2'b01:   return CNT_W'(MID_DIV);
            default: return CNT_W'(FAST_DIV);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] ticks_for_stop(input logic [1:0] r,
                                                        input logic [1:0] s);
        logic [CNT_W-1:0] one;
        one = ticks_per_bit(r);
        unique case (s)
            2'b00:   return one;
            2'b01:   return (r == 2'b00) ? (one << 1) : (one + (one >> 1));
            default: return one << 1;
        endcase
    endfunction

    assign masked   = hold_data & ({DW{1'b1}} >> (LEN_SPAN - int'(cfg.len)));
    assign last_idx = IDX_W'(len_q) + IDX_W'(MIN_BITS - 1);

    // next-state and datapath decisions
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        idx_d   = idx_q;
        par_d   = par_q;
        len_d   = len_q;
        paren_d = paren_q;
        stop_d  = stop_q;
        rate_d  = rate_q;
        load    = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (hold_full) load = 1'b1;
            end
            TX_START: begin
                if (bit_done) begin
                    state_d = TX_DATA;
                    idx_d   = '0;
                end
            end
            TX_DATA: begin
                if (bit_done) begin
                    shreg_d = shreg_q >> 1;
                    par_d   = par_q ^ shreg_q[0];
                    if (idx_q == last_idx) begin
                        state_d = paren_q ? TX_PARITY : TX_STOP;
                    end else begin
                        idx_d = idx_q + 1'b1;
                    end
                end
            end
            TX_PARITY: begin
                if (bit_done) state_d = TX_STOP;
            end
            TX_STOP: begin
                if (bit_done) begin
                    if (hold_full) load = 1'b1;
                    else           state_d = TX_IDLE;
                end
            end
            default: state_d = TX_IDLE;
        endcase
        if (load) begin
            state_d = TX_START;
            shreg_d = masked;
            idx_d   = '0;
            par_d   = cfg.par_odd;
            len_d   = cfg.len;
            paren_d = cfg.par_en;
            stop_d  = cfg.stop;
            rate_d  = cfg.rate;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            par_q   <= 1'b0;
            len_q   <= 2'b11;
            paren_q <= 1'b0;
            stop_q  <= 2'b00;
            rate_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            idx_q   <= idx_d;
            par_q   <= par_d;
            len_q   <= len_d;
            paren_q <= paren_d;
            stop_q  <= stop_d;
            rate_q  <= rate_d;
        end
    end

    // outputs
    always_comb begin
        ser_out     = 1'b1;
        shift_empty = 1'b0;
        unique case (state_q)
            TX_IDLE:   shift_empty = 1'b1;
            TX_START:  ser_out = 1'b0;
            TX_DATA:   ser_out = shreg_q[0];
            TX_PARITY: ser_out = par_q;
            TX_STOP:   ser_out = 1'b1;
            default:   shift_empty = 1'b1;
        endcase
        run   = (state_q != TX_IDLE);
        limit = (state_q == TX_STOP) ? ticks_for_stop(rate_q, stop_q)
                                     : ticks_per_bit(rate_q);
        take  = load;
    end

    // R1
    idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_IDLE && !hold_full) |=> (state_q == TX_IDLE));

    // R4
    start_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == TX_START && !bit_done) |=> (state_q == TX_START));

endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
    import sertx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int MID_DIV  = 16,
    parameter int FAST_DIV = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic [1:0]        cfg_rate,
    output logic              ser_out,
    output logic              hold_empty,
    output logic              shift_empty
);
    localparam int CNT_W = $clog2(2 * FAST_DIV + 1);

    frame_cfg_t        cfg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              take;
    logic              run;
    logic [CNT_W-1:0]  limit;
    logic              bit_done;

    assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_odd: cfg_par_odd,
                   stop: cfg_stop, rate: cfg_rate};

    sertx_hold #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    sertx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .tick     (tx_tick),
        .limit    (limit),
        .bit_done (bit_done)
    );

    sertx_frame_fsm #(
        .DW       (DATA_W),
        .CNT_W    (CNT_W),
        .MID_DIV  (MID_DIV),
        .FAST_DIV (FAST_DIV)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .hold_full   (hold_full),
        .hold_data   (hold_data),
        .cfg         (cfg),
        .bit_done    (bit_done),
        .take        (take),
        .run         (run),
        .limit       (limit),
        .ser_out     (ser_out),
        .shift_empty (shift_empty)
    );

    assign hold_empty = !hold_full;

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ser_out && hold_empty && shift_empty));

    // R2
    accept_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && hold_empty) |=> !hold_empty);

    // R11
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        shift_empty |-> ser_out);

endmodule

// File: tb/serial_tx_dbuf_test.sv
module serial_tx_dbuf_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic [1:0] cfg_stop = 2'b00;
    logic [1:0] cfg_rate = 2'b00;
    logic       ser_out, hold_empty, shift_empty;

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R9";
    int    tgap = 1;
    int    tphase = 0;
    bit    started = 0;

    always #5 clk = ~clk;

    serial_tx_dbuf uut (
        .clk(clk), .rst(rst), .tx_tick(tx_tick), .wr_en(wr_en), .wr_data(wr_data),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop(cfg_stop), .cfg_rate(cfg_rate),
        .ser_out(ser_out), .hold_empty(hold_empty), .shift_empty(shift_empty)
    );

    // tick enable generator
    always @(negedge clk) begin
        #1;
        if (tgap <= 1) begin
            tx_tick = 1'b1;
        end else begin
            tx_tick = (tphase == tgap - 1);
            tphase  = (tphase + 1) % tgap;
        end
    end

    // behavioural reference: queue of (level, ticks) per frame
    int q_lvl[$];
    int q_dur[$];
    bit m_full = 0;
    logic [7:0] m_hold = 8'h00;
    bit e_ser = 1, e_rdy = 1, e_emp = 1;

    function automatic void push_bit(int lvl, int dur);
        q_lvl.push_back(lvl);
        q_dur.push_back(dur);
    endfunction

    function automatic void build_frame();
        int nb, f, ones, st;
        nb = 5 + int'(cfg_len);
        f = (cfg_rate == 2'b00) ? 1 : (cfg_rate == 2'b01) ? 16 : 64;
        ones = 0;
        push_bit(0, f);
        for (int i = 0; i < nb; i++) begin
            int b;
            b = int'((m_hold >> i) & 8'h01);
            ones += b;
            push_bit(b, f);
        end
        if (cfg_par_en) push_bit(cfg_par_odd ? ((ones % 2) == 0) : (ones % 2), f);
        if (cfg_stop == 2'b00)      st = f;
        else if (cfg_stop == 2'b01) st = (f == 1) ? 2 : f + f / 2;
        else                        st = 2 * f;
        push_bit(1, st);
    endfunction

    always @(posedge clk) begin
        bit was_idle, ended, pre_full;
        if (rst) begin
            q_lvl.delete();
            q_dur.delete();
            m_full = 0;
            started = 1;
        end else begin
            was_idle = (q_lvl.size() == 0);
            ended = 0;
            pre_full = m_full;
            if (!was_idle && tx_tick) begin
                q_dur[0] = q_dur[0] - 1;
                if (q_dur[0] == 0) begin
                    void'(q_lvl.pop_front());
                    void'(q_dur.pop_front());
                    if (q_lvl.size() == 0) ended = 1;
                end
            end
            if (wr_en && !pre_full) begin
                m_full = 1;
                m_hold = wr_data;
            end
            if (pre_full && (was_idle || ended)) begin
                build_frame();
                m_full = 0;
            end
        end
        e_ser = (q_lvl.size() == 0) ? 1'b1 : q_lvl[0][0];
        e_rdy = !m_full;
        e_emp = (q_lvl.size() == 0);
    end

    // per-cycle comparison, half a cycle after each update
    always @(negedge clk) begin
        if (started) begin
            checks += 3;
            if (ser_out !== e_ser) begin
                failures++;
                $display("FAIL %s ser_out actual=%b expected=%b t=%0t", cur_req, ser_out, e_ser, $time);
            end
            if (hold_empty !== e_rdy) begin
                failures++;
                $display("FAIL R2 hold_empty actual=%b expected=%b t=%0t", hold_empty, e_rdy, $time);
            end
            if (shift_empty !== e_emp) begin
                failures++;
                $display("FAIL R3 shift_empty actual=%b expected=%b t=%0t", shift_empty, e_emp, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input logic [1:0] len, input logic pe, input logic po,
                           input logic [1:0] st, input logic [1:0] rt, input int gap);
        @(negedge clk); #2;
        cfg_len = len; cfg_par_en = pe; cfg_par_odd = po;
        cfg_stop = st; cfg_rate = rt; tgap = gap; tphase = 0;
    endtask

    task automatic wait_idle();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(shift_empty === 1'b1 && hold_empty === 1'b1) && n < 20000);
        repeat (2) @(negedge clk);
    endtask

    task automatic measure_busy(output int n);
        int w;
        w = 0;
        n = 0;
        @(negedge clk);
        while (shift_empty !== 1'b0 && w < 20) begin
            @(negedge clk);
            w++;
        end
        while (shift_empty === 1'b0 && n < 20000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        repeat (145000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9 ser_out", ser_out, 1);
        chk("R9 hold_empty", hold_empty, 1);
        chk("R9 shift_empty", shift_empty, 1);

        // R4: 8N1 at 1x
        cur_req = "R4";
        set_cfg(2'b11, 0, 0, 2'b00, 2'b00, 1);
        send(8'hA5);
        wait_idle();

        // R1/R2/R3/R8: queuing while a frame runs
        cur_req = "R1";
        set_cfg(2'b11, 0, 0, 2'b00, 2'b01, 1);
        send(8'h3C);
        chk("R2 hold_empty after write", hold_empty, 0);
        @(negedge clk);
        chk("R1 transferred hold_empty", hold_empty, 1);
        chk("R3 shift_empty in frame", shift_empty, 0);
        chk("R4 start bit", ser_out, 0);
        send(8'hC3);
        chk("R2 second write held", hold_empty, 0);
        cur_req = "R8";
        send(8'hFF);
        chk("R8 write while full ignored", hold_empty, 0);
        wait_idle();
        chk("R3 idle after frames", shift_empty, 1);

        // R6: start bit at 16x is 16 ticks
        cur_req = "R6";
        send(8'h81);
        n = 0;
        begin
            int w;
            w = 0;
            while (ser_out !== 1'b0 && w < 20) begin @(negedge clk); w++; end
            while (ser_out === 1'b0 && n < 200) begin n++; @(negedge clk); end
        end
        chk("R6 start bit length 16x", n, 16);
        wait_idle();

        // R5/R7: 5 bits, even parity, 1.5 stop at 16x: (1+5+1)*16+24 ticks
        cur_req = "R7";
        set_cfg(2'b00, 1, 0, 2'b01, 2'b01, 1);
        send(8'h13);
        measure_busy(n);
        chk("R7 frame ticks 16x 1.5 stop", n, 136);
        wait_idle();

        // R5: 7 bits, odd parity, 2 stop at 64x, tick every 2 clocks
        cur_req = "R5";
        set_cfg(2'b10, 1, 1, 2'b10, 2'b10, 2);
        send(8'h55);
        wait_idle();
        set_cfg(2'b11, 1, 1, 2'b00, 2'b00, 1);
        send(8'h0F);
        wait_idle();

        // R7: 1x with 1.5 stop gives two stop bits: 1+6+2 ticks
        cur_req = "R7";
        set_cfg(2'b01, 0, 0, 2'b01, 2'b00, 1);
        send(8'h2A);
        measure_busy(n);
        chk("R7 1x stop treated as two", n, 9);
        wait_idle();

        // R1: back-to-back chaining with sparse ticks
        cur_req = "R1";
        set_cfg(2'b01, 1, 0, 2'b01, 2'b00, 3);
        send(8'h2A);
        repeat (2) @(negedge clk);
        send(8'h15);
        wait_idle();

        // R10: mode change mid-frame has no effect on that frame
        cur_req = "R10";
        set_cfg(2'b11, 0, 0, 2'b00, 2'b01, 1);
        send(8'h0F);
        repeat (40) @(negedge clk);
        #2;
        cfg_len = 2'b00; cfg_par_en = 1'b1; cfg_rate = 2'b00;
        n = 40;
        while (shift_empty === 1'b0 && n < 1000) begin n++; @(negedge clk); end
        chk("R10 frame length unchanged", n, 161);
        wait_idle();

        // R11: line stays high with nothing to send
        cur_req = "R11";
        n = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ser_out === 1'b1) n++;
        end
        chk("R11 idle line high", n, 30);

        finish_run();
    end

endmodule